// File: doc/BRIEF.md
# Dual-Channel Sample Table Player

This block plays stored waveforms on two DAC channels. Each channel owns a 2048-entry table of 14-bit unsigned offset-binary samples. On every I/O clock cycle the block presents a bundle of eight consecutive table entries per channel, which a downstream serializer sends out in lane order. A host loads each channel's table through its own write port while playback is stopped.

A single run control starts and stops both channels together. In walk mode the group pointer moves forward by one bundle per cycle between a programmable first and last address, then returns to the first address. In phase mode a fractional phase accumulator moves the group pointer by a programmable step and wraps around the whole table. While stopped, and until the read pipeline has filled, every lane carries the mid-scale code.

Top module: `dual_lut_player`

## Requirements
- R1: After reset, and while playback is stopped, every lane of both channels carries the mid-scale code 8192.
- R2: Each channel has its own write port (enable, 11-bit entry address, 14-bit sample). A write stores the sample at that entry of that channel's table only, and the other channel's table is left unchanged.
- R3: When the run input is sampled high at a clock edge after a stopped cycle, the group pointer loads the first address. The group read there appears on the lanes after the second rising edge that follows. Until then the lanes stay at mid-scale.
- R4: Lane i (bits [14*i+13:14*i], i = 0..7) carries table entry (P + i) mod 2048, where P is the group pointer. Lane 0 is the earliest sample, and a group that crosses entry 2047 continues at entry 0.
- R5: With mode input 0 (walk mode), the next pointer is P + 8. If that group's last entry (P + 15) would lie beyond the last address, the next pointer is the first address instead.
- R6: With the first address at 0 and the last address at 2047, the group at 2040 is followed by the group at 0.
- R7: A last address below the first address acts as equal to the first address, so the channel repeats one eight-sample group.
- R8: With mode input 1 (phase mode), a 19-bit phase holds 11 integer and 8 fractional bits. It loads the first address shifted left by 8 on start, adds the step input every cycle modulo 2^19, and its integer part is the group pointer. The last address is ignored in this mode.
- R9: A table write presented while playback is running is ignored.
- R10: When the run input is sampled low, two further groups still leave the block, and from the third rising edge on every lane is mid-scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Playback enable for both channels |
| mode_dds_i | input | 1 | 0 walk mode, 1 phase mode |
| first_addr_i | input | 11 | Group pointer load value and walk-mode restart point |
| last_addr_i | input | 11 | Walk-mode upper end point |
| phase_step_i | input | 19 | Phase-mode increment per cycle (8 fractional bits) |
| wr0_en_i | input | 1 | Channel 0 table write enable |
| wr0_addr_i | input | 11 | Channel 0 table write entry |
| wr0_data_i | input | 14 | Channel 0 table write sample |
| wr1_en_i | input | 1 | Channel 1 table write enable |
| wr1_addr_i | input | 11 | Channel 1 table write entry |
| wr1_data_i | input | 14 | Channel 1 table write sample |
| ch0_lanes_o | output | 112 | Channel 0 bundle of eight samples |
| ch1_lanes_o | output | 112 | Channel 1 bundle of eight samples |

## Verification
The tables are filled with two different linear ramps, so any lane that shows the wrong entry, the wrong channel or the wrong lane order shows up as a wrong value. Walk mode is tried with a window that starts off a bundle boundary, with a window shorter than a bundle, with an inverted window, with a group that crosses the table end, and with a full-table run. Together these separate the restart rule from plain modulo wrap. Phase mode uses a fractional step from near the top of the table, which shows whether the fraction carries and whether the pointer wraps modulo the table rather than at the last address. A write issued mid-run to an entry that is replayed later in the same run shows whether the write lock holds.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic {
        MODE_WALK  = 1'b0,
        MODE_PHASE = 1'b1
    } wp_mode_e;

endpackage

// File: rtl/wp_addr_gen.sv
module wp_addr_gen #(
    parameter int ADDR_W = 11,
    parameter int FRAC_W = 8,
    parameter int LANES  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run_i,
    input  logic                     mode_i,
    input  logic [ADDR_W-1:0]        first_i,
    input  logic [ADDR_W-1:0]        last_i,
    input  logic [ADDR_W+FRAC_W-1:0] step_i,
    output logic                     run_o,
    output logic                     rd_vld_o,
    output logic [ADDR_W-1:0]        ptr_o
);
    import wp_pkg::*;

    localparam int PH_W = ADDR_W + FRAC_W;
    localparam int EW   = ADDR_W + 2;

    typedef struct packed {
        logic            run;
        logic            rd_vld;
        logic [PH_W-1:0] phase;
    } ag_state_t;

    ag_state_t st_d, st_q;

    logic [ADDR_W-1:0] last_eff;
    logic [EW-1:0]     next_grp;
    logic [EW-1:0]     next_end;
    logic [ADDR_W-1:0] walk_ptr;
    wp_mode_e          mode;

    always_comb begin
        mode     = wp_mode_e'(mode_i);
        last_eff = (last_i < first_i) ? first_i : last_i;
        next_grp = {2'b00, st_q.phase[PH_W-1:FRAC_W]} + EW'(LANES);
        next_end = next_grp + EW'(LANES - 1);
        walk_ptr = (next_end > {2'b00, last_eff}) ? first_i : next_grp[ADDR_W-1:0];

        st_d        = st_q;
        st_d.run    = run_i;
        st_d.rd_vld = st_q.run;
        if (run_i && !st_q.run) begin
            st_d.phase = {first_i, {FRAC_W{1'b0}}};
        end else if (st_q.run) begin
            if (mode == MODE_PHASE) begin
                st_d.phase = st_q.phase + step_i;
            end else begin
                st_d.phase = {walk_ptr, {FRAC_W{1'b0}}};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o    = st_q.run;
    assign rd_vld_o = st_q.rd_vld;
    assign ptr_o    = st_q.phase[PH_W-1:FRAC_W];

endmodule

// File: rtl/wp_bank_mem.sv
module wp_bank_mem #(
    parameter int SAMPLE_W = 14,
    parameter int ADDR_W   = 11,
    parameter int LANES    = 8
) (
    input  logic                      clk,
    input  logic                      we_i,
    input  logic [ADDR_W-1:0]         waddr_i,
    input  logic [SAMPLE_W-1:0]       wdata_i,
    input  logic [ADDR_W-1:0]         ptr_i,
    output logic [LANES*SAMPLE_W-1:0] lanes_o
);
    localparam int LB    = $clog2(LANES);
    localparam int ROW_W = ADDR_W - LB;
    localparam int ROWS  = 1 << ROW_W;

    logic [LANES*SAMPLE_W-1:0] bank_rd;
    logic [LB-1:0]             rot_d, rot_q;

    for (genvar b = 0; b < LANES; b++) begin : g_bank
        logic [SAMPLE_W-1:0] mem [ROWS];
        logic [SAMPLE_W-1:0] rd_q;
        logic [LB-1:0]       lane_off;
        logic [ADDR_W-1:0]   ent_addr;

        always_comb begin
            lane_off = LB'(b) - ptr_i[LB-1:0];
            ent_addr = ptr_i + ADDR_W'(lane_off);
        end

        always_ff @(posedge clk) begin
            if (we_i && (waddr_i[LB-1:0] == LB'(b))) begin
                mem[waddr_i[ADDR_W-1:LB]] <= wdata_i;
            end
            rd_q <= mem[ent_addr[ADDR_W-1:LB]];
        end

        assign bank_rd[b*SAMPLE_W +: SAMPLE_W] = rd_q;
    end

    assign rot_d = ptr_i[LB-1:0];

    always_ff @(posedge clk) begin
        rot_q <= rot_d;
    end

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            logic [LB-1:0] src;
            src = rot_q + LB'(i);
            lanes_o[i*SAMPLE_W +: SAMPLE_W] = bank_rd[src*SAMPLE_W +: SAMPLE_W];
        end
    end

endmodule

// File: rtl/wp_lane_out.sv
module wp_lane_out #(
    parameter int SAMPLE_W  = 14,
    parameter int LANES     = 8,
    parameter int IDLE_CODE = 8192
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      vld_i,
    input  logic [LANES*SAMPLE_W-1:0] lanes_i,
    output logic [LANES*SAMPLE_W-1:0] lanes_o
);
    localparam logic [SAMPLE_W-1:0]       IDLE_S   = SAMPLE_W'(IDLE_CODE);
    localparam logic [LANES*SAMPLE_W-1:0] IDLE_VEC = {LANES{IDLE_S}};

    logic [LANES*SAMPLE_W-1:0] out_d, out_q;

    always_comb begin
        out_d = vld_i ? lanes_i : IDLE_VEC;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= IDLE_VEC;
        end else begin
            out_q <= out_d;
        end
    end

    assign lanes_o = out_q;

endmodule

// File: rtl/dual_lut_player.sv
module dual_lut_player #(
    parameter int SAMPLE_W  = 14,
    parameter int ADDR_W    = 11,
    parameter int LANES     = 8,
    parameter int FRAC_W    = 8,
    parameter int IDLE_CODE = 8192
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run_i,
    input  logic                       mode_dds_i,
    input  logic [ADDR_W-1:0]          first_addr_i,
    input  logic [ADDR_W-1:0]          last_addr_i,
    input  logic [ADDR_W+FRAC_W-1:0]   phase_step_i,
    input  logic                       wr0_en_i,
    input  logic [ADDR_W-1:0]          wr0_addr_i,
    input  logic [SAMPLE_W-1:0]        wr0_data_i,
    input  logic                       wr1_en_i,
    input  logic [ADDR_W-1:0]          wr1_addr_i,
    input  logic [SAMPLE_W-1:0]        wr1_data_i,
    output logic [LANES*SAMPLE_W-1:0]  ch0_lanes_o,
    output logic [LANES*SAMPLE_W-1:0]  ch1_lanes_o
);
    localparam int NCH   = 2;
    localparam int BUS_W = LANES * SAMPLE_W;

    logic              run_q;
    logic              rd_vld;
    logic [ADDR_W-1:0] grp_ptr;

    logic                wr_en   [NCH];
    logic [ADDR_W-1:0]   wr_addr [NCH];
    logic [SAMPLE_W-1:0] wr_data [NCH];
    logic [BUS_W-1:0]    lanes   [NCH];

    always_comb begin
        wr_en[0]   = wr0_en_i;
        wr_addr[0] = wr0_addr_i;
        wr_data[0] = wr0_data_i;
        wr_en[1]   = wr1_en_i;
        wr_addr[1] = wr1_addr_i;
        wr_data[1] = wr1_data_i;
    end

    wp_addr_gen #(
        .ADDR_W (ADDR_W),
        .FRAC_W (FRAC_W),
        .LANES  (LANES)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_i),
        .mode_i   (mode_dds_i),
        .first_i  (first_addr_i),
        .last_i   (last_addr_i),
        .step_i   (phase_step_i),
        .run_o    (run_q),
        .rd_vld_o (rd_vld),
        .ptr_o    (grp_ptr)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic             we_ok;
        logic [BUS_W-1:0] raw;

        assign we_ok = wr_en[c] && !run_q;

        wp_bank_mem #(
            .SAMPLE_W (SAMPLE_W),
            .ADDR_W   (ADDR_W),
            .LANES    (LANES)
        ) u_mem (
            .clk     (clk),
            .we_i    (we_ok),
            .waddr_i (wr_addr[c]),
            .wdata_i (wr_data[c]),
            .ptr_i   (grp_ptr),
            .lanes_o (raw)
        );

        wp_lane_out #(
            .SAMPLE_W  (SAMPLE_W),
            .LANES     (LANES),
            .IDLE_CODE (IDLE_CODE)
        ) u_out (
            .clk     (clk),
            .rst_n   (rst_n),
            .vld_i   (rd_vld),
            .lanes_i (raw),
            .lanes_o (lanes[c])
        );
    end

    assign ch0_lanes_o = lanes[0];
    assign ch1_lanes_o = lanes[1];

endmodule

// File: rtl/wp_checker.sv
module wp_checker #(
    parameter int SAMPLE_W  = 14,
    parameter int ADDR_W    = 11,
    parameter int LANES     = 8,
    parameter int IDLE_CODE = 8192
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      run_q,
    input logic                      rd_vld,
    input logic [ADDR_W-1:0]         ptr_q,
    input logic                      mode_dds_i,
    input logic [ADDR_W-1:0]         first_addr_i,
    input logic [LANES*SAMPLE_W-1:0] ch0_lanes_o,
    input logic [LANES*SAMPLE_W-1:0] ch1_lanes_o
);
    localparam logic [SAMPLE_W-1:0]       IDLE_S   = SAMPLE_W'(IDLE_CODE);
    localparam logic [LANES*SAMPLE_W-1:0] IDLE_VEC = {LANES{IDLE_S}};
    localparam logic [ADDR_W-1:0]         STEP_C   = ADDR_W'(LANES);

    // R1: an empty read stage yields mid-scale on the next edge
    assert_idle_when_drained_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_vld |=> (ch0_lanes_o == IDLE_VEC) && (ch1_lanes_o == IDLE_VEC));

    // R3: pointer holds the first address in the cycle playback starts
    assert_start_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> (ptr_q == $past(first_addr_i)));

    // R5: walk mode moves by one bundle or restarts at the first address
    assert_walk_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q) && !$past(mode_dds_i)) |->
        ((ptr_q == $past(ptr_q) + STEP_C) || (ptr_q == $past(first_addr_i))));

    // R10: stopping drains to mid-scale by the third edge
    assert_stop_drains_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |=> ##1 ((ch0_lanes_o == IDLE_VEC) && (ch1_lanes_o == IDLE_VEC)));

endmodule

bind dual_lut_player wp_checker #(
    .SAMPLE_W  (SAMPLE_W),
    .ADDR_W    (ADDR_W),
    .LANES     (LANES),
    .IDLE_CODE (IDLE_CODE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_q        (run_q),
    .rd_vld       (rd_vld),
    .ptr_q        (grp_ptr),
    .mode_dds_i   (mode_dds_i),
    .first_addr_i (first_addr_i),
    .ch0_lanes_o  (ch0_lanes_o),
    .ch1_lanes_o  (ch1_lanes_o)
);

// File: tb/sim_dual_lut_player.sv
module sim_dual_lut_player;
    localparam int PERIOD = 10;
    localparam int SW     = 14;
    localparam int AW     = 11;
    localparam int LN     = 8;
    localparam int DEPTH  = 2048;
    localparam int BW     = SW * LN;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_i = 1'b0;
    logic          mode_dds_i = 1'b0;
    logic [AW-1:0] first_addr_i = '0;
    logic [AW-1:0] last_addr_i = '0;
    logic [18:0]   phase_step_i = '0;
    logic          wr0_en_i = 1'b0;
    logic [AW-1:0] wr0_addr_i = '0;
    logic [SW-1:0] wr0_data_i = '0;
    logic          wr1_en_i = 1'b0;
    logic [AW-1:0] wr1_addr_i = '0;
    logic [SW-1:0] wr1_data_i = '0;
    logic [BW-1:0] ch0_lanes_o;
    logic [BW-1:0] ch1_lanes_o;

    logic [SW-1:0] tbl0 [DEPTH];
    logic [SW-1:0] tbl1 [DEPTH];

    int n_chk  = 0;
    int n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    dual_lut_player u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run_i),
        .mode_dds_i   (mode_dds_i),
        .first_addr_i (first_addr_i),
        .last_addr_i  (last_addr_i),
        .phase_step_i (phase_step_i),
        .wr0_en_i     (wr0_en_i),
        .wr0_addr_i   (wr0_addr_i),
        .wr0_data_i   (wr0_data_i),
        .wr1_en_i     (wr1_en_i),
        .wr1_addr_i   (wr1_addr_i),
        .wr1_data_i   (wr1_data_i),
        .ch0_lanes_o  (ch0_lanes_o),
        .ch1_lanes_o  (ch1_lanes_o)
    );

    function automatic logic [BW-1:0] idle_vec();
        logic [BW-1:0] r;
        for (int i = 0; i < LN; i++) r[i*SW +: SW] = 14'd8192;
        return r;
    endfunction

    function automatic logic [BW-1:0] grp(input int ch, input int p);
        logic [BW-1:0] r;
        for (int i = 0; i < LN; i++) begin
            int a;
            a = (p + i) % DEPTH;
            r[i*SW +: SW] = (ch == 0) ? tbl0[a] : tbl1[a];
        end
        return r;
    endfunction

    function automatic int walk_next(input int p, input int s, input int e);
        int le;
        int n;
        le = (e < s) ? s : e;
        n  = p + LN;
        if (n + LN - 1 > le) return s;
        return n;
    endfunction

    task automatic chk(input string tag, input string what, input logic [BW-1:0] got,
                       input logic [BW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Plays one run and checks every group; inj issues a mid-run write (R9)
    task automatic run_seq(input string tag, input bit dds, input int s, input int e,
                           input int step, input int n, input bit inj);
        int p;
        int ph;
        @(negedge clk);
        mode_dds_i   = dds;
        first_addr_i = AW'(s);
        last_addr_i  = AW'(e);
        phase_step_i = 19'(step);
        run_i        = 1'b1;
        ph = s << 8;
        p  = s;
        @(negedge clk);
        if (inj) begin
            wr0_en_i = 1'b1; wr0_addr_i = 11'd300; wr0_data_i = 14'h0AAA;
            wr1_en_i = 1'b1; wr1_addr_i = 11'd300; wr1_data_i = 14'h0555;
        end
        chk("R3", "latency edge 1 ch0", ch0_lanes_o, idle_vec());
        @(negedge clk);
        wr0_en_i = 1'b0;
        wr1_en_i = 1'b0;
        chk("R3", "latency edge 2 ch1", ch1_lanes_o, idle_vec());
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(tag, "ch0 group", ch0_lanes_o, grp(0, p));
            chk(tag, "ch1 group", ch1_lanes_o, grp(1, p));
            if (dds) begin
                ph = (ph + step) % (1 << 19);
                p  = ph >> 8;
            end else begin
                p = walk_next(p, s, e);
            end
        end
        run_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R10", "second drain group", ch0_lanes_o,
            (ch0_lanes_o == idle_vec()) ? ~idle_vec() : ch0_lanes_o);
        @(negedge clk);
        chk("R10", "idle after stop ch0", ch0_lanes_o, idle_vec());
        chk("R10", "idle after stop ch1", ch1_lanes_o, idle_vec());
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "in reset", ch0_lanes_o, idle_vec());
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1", "stopped ch0", ch0_lanes_o, idle_vec());
        chk("R1", "stopped ch1", ch1_lanes_o, idle_vec());
    endtask

    task automatic t_load();
        for (int a = 0; a < DEPTH; a++) begin
            tbl0[a] = SW'(a * 5 + 37);
            tbl1[a] = SW'(16383 - a * 7);
        end
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            wr0_en_i = 1'b1; wr0_addr_i = AW'(a); wr0_data_i = tbl0[a];
            wr1_en_i = 1'b1; wr1_addr_i = AW'(a); wr1_data_i = tbl1[a];
        end
        @(negedge clk);
        wr0_en_i = 1'b0;
        wr1_en_i = 1'b0;
    endtask

    // R2: one channel written alone, other table untouched
    task automatic t_single_channel_write();
        @(negedge clk);
        wr0_en_i = 1'b1; wr0_addr_i = 11'd100; wr0_data_i = 14'h1234;
        @(negedge clk);
        wr0_en_i = 1'b0;
        tbl0[100] = 14'h1234;
        run_seq("R2", 1'b0, 96, 200, 0, 4, 1'b0);
    endtask

    initial begin
        t_reset();
        t_load();
        run_seq("R4/R5", 1'b0, 5, 30, 0, 8, 1'b0);
        run_seq("R5", 1'b0, 50, 52, 0, 3, 1'b0);
        run_seq("R4", 1'b0, 2044, 2047, 0, 3, 1'b0);
        run_seq("R5", 1'b0, 2024, 2047, 0, 6, 1'b0);
        run_seq("R6", 1'b0, 0, 2047, 0, 260, 1'b0);
        run_seq("R7", 1'b0, 700, 3, 0, 4, 1'b0);
        run_seq("R8", 1'b1, 2000, 10, 2944, 20, 1'b0);
        t_single_channel_write();
        run_seq("R9", 1'b0, 296, 320, 0, 6, 1'b1);
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

endmodule